// File: doc/BRIEF.md
# Jumbo-Prefix Lane Immediate Assembler

This block sits at the decode stage of a three-lane superscalar front end. It takes a bundle of consecutive 32-bit words in program order (lane 0 is the oldest). A word whose low six bits carry the prefix tag is a jumbo prefix. Its upper 26 bits are a payload that widens the immediate of the instruction that follows it. Each lane decoder receives the payload of the word just before it, and the oldest lane receives none. A lane that holds only a prefix has its op replaced by a NOP. Every lane emits a 33-bit immediate fragment.

One clock later, at the register-fetch step, a stitch stage joins the fragments into a full 64-bit immediate for every lane that holds a base instruction. It handles three encodings. A bare instruction (32-bit) carries a 12-bit immediate. One prefix followed by the instruction (64-bit) widens it to 33 bits, and the top bits are extended by a mode bit. Two prefixes followed by the instruction (96-bit) give a fully specified 64-bit value.

The outputs are delivered in physical lane order. By default bundles are right-aligned, so physical slot 0 carries the youngest word.

Top module: `jpx_imm_assembler`

## Requirements
- R1: A word whose bits 5:0 equal 6'h3F is a prefix. Its lane raises its NOP flag and its op output becomes 32'h0000_0000. Any other word raises no NOP flag and passes its op through unchanged.
- R2: Program lane 0 never receives extension bits. A lane k>0 receives the payload (bits 31:6) of word k-1 only when word k-1 is a prefix.
- R3: A base word with no prefix before it yields a fragment equal to its bits 31:20, sign-extended to 33 bits.
- R4: A base word after a prefix P yields the fragment {P[26:6], word[31:20]}.
- R5: A prefix with no prefix before it yields the fragment {28'b0, word[31:27]}.
- R6: A prefix preceded by a prefix Q takes the 96-bit role. Its fragment is {2'b0, Q[31:6], word[31:27]}.
- R7: The assembled immediates appear one clock after a bundle is presented with in_valid high. rf_valid equals in_valid delayed by one clock.
- R8: For a base lane with no prefix before it, the assembled immediate is its fragment sign-extended to 64 bits.
- R9: For a base lane preceded by exactly one prefix P, the assembled immediate is {upper31, fragment}. When P[31] is 1, upper31 is P[30:27] zero-extended. When P[31] is 0, upper31 is P[30:27] sign-extended.
- R10: For a base lane preceded by two prefixes, the assembled immediate is {fragment of the lane before [30:0], own fragment}.
- R11: A prefix lane's assembled immediate is zero, and its registered NOP flag is set.
- R12: With right alignment, physical slot p carries program lane NUM_LANES-1-p on every per-lane output.
- R13: Reset clears rf_valid, rf_nop and rf_imm. While in_valid is low, rf_nop and rf_imm hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Bundle present this cycle |
| in_words | input | NUM_LANES*32 | Bundle, program lane k at bits [32k+31:32k] |
| dec_op | output | NUM_LANES*32 | Per-slot op, NOP for prefix lanes |
| dec_nop | output | NUM_LANES | Per-slot prefix-only flag |
| dec_frag | output | NUM_LANES*33 | Per-slot immediate fragment |
| rf_valid | output | 1 | Registered immediates valid |
| rf_nop | output | NUM_LANES | Registered per-slot NOP flag |
| rf_imm | output | NUM_LANES*64 | Registered per-slot assembled immediate |

## Verification
The assertions assume that the fragment kinds handed to the stitch stage are consistent with each other: a 96-bit-role prefix always sits directly after another prefix, and lane 0 is never extended. They also assume that an unextended fragment is a true sign extension of its 12-bit field. These facts hold only when in_valid qualifies a settled bundle, so the bench changes in_words solely at falling edges. Random bundles set the prefix tag in about 40% of words and otherwise force the low six bits away from the tag. In this way every chain of zero, one, two or three prefixes occurs, alongside directed bundles for each mode of the extension bit.

// File: rtl/jpx_pkg.sv
package jpx_pkg;

   // Role of a lane's 33-bit fragment, as seen by the stitch stage.
   typedef enum logic [1:0] {
      FK_SHORT = 2'd0,   // base word, no prefix before it
      FK_LONG  = 2'd1,   // base word, extended by its predecessor
      FK_TOP   = 2'd2,   // prefix alone: carries mode bit and top data
      FK_HIGH  = 2'd3    // prefix after prefix: carries high bits
   } frag_kind_e;

endpackage

// File: rtl/jpx_lane_dec.sv
module jpx_lane_dec
   import jpx_pkg::*;
#(
   parameter int                WORD_W     = 32,
   parameter int                TAG_W      = 6,
   parameter logic [TAG_W-1:0]  PFX_TAG    = '1,
   parameter int                BASE_IMM_W = 12,
   parameter int                FRAG_W     = 33,
   parameter logic [WORD_W-1:0] NOP_OP     = '0
) (
   input  logic [WORD_W-1:0]       word,
   input  logic [WORD_W-TAG_W-1:0] ext_pay,
   input  logic                    ext_vld,
   output logic                    is_pfx,
   output logic [WORD_W-1:0]       op_out,
   output logic [FRAG_W-1:0]       frag,
   output frag_kind_e              kind
);

   localparam int PAY_W    = WORD_W - TAG_W;
   localparam int LOWEXT_W = FRAG_W - BASE_IMM_W;
   localparam int TOP_W    = PAY_W - LOWEXT_W;
   localparam int HI_W     = PAY_W + TOP_W;
   localparam int PAD_HI   = FRAG_W - HI_W;
   localparam int PAD_TOP  = FRAG_W - TOP_W;

   logic [PAY_W-1:0]      pay;
   logic [BASE_IMM_W-1:0] base_imm;
   logic [TOP_W-1:0]      top_bits;

   assign pay      = word[WORD_W-1:TAG_W];
   assign base_imm = word[WORD_W-1 -: BASE_IMM_W];
   assign top_bits = pay[PAY_W-1 -: TOP_W];
   assign is_pfx   = (word[TAG_W-1:0] == PFX_TAG);
   assign op_out   = is_pfx ? NOP_OP : word;

   always_comb begin
      if (!is_pfx) begin
         if (ext_vld) begin
            frag = {ext_pay[LOWEXT_W-1:0], base_imm};
            kind = FK_LONG;
         end else begin
            frag = {{LOWEXT_W{base_imm[BASE_IMM_W-1]}}, base_imm};
            kind = FK_SHORT;
         end
      end else if (ext_vld) begin
         frag = {{PAD_HI{1'b0}}, ext_pay, top_bits};
         kind = FK_HIGH;
      end else begin
         frag = {{PAD_TOP{1'b0}}, top_bits};
         kind = FK_TOP;
      end
   end

endmodule

// File: rtl/jpx_imm_stitch.sv
module jpx_imm_stitch
   import jpx_pkg::*;
#(
   parameter int NUM_LANES  = 3,
   parameter int FRAG_W     = 33,
   parameter int IMM_W      = 64,
   parameter int TOP_W      = 5,
   parameter int BASE_IMM_W = 12
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          in_valid,
   input  logic [NUM_LANES*FRAG_W-1:0]   frag,
   input  frag_kind_e [NUM_LANES-1:0]    kind,
   input  logic [NUM_LANES-1:0]          lane_nop,
   output logic                          rf_valid,
   output logic [NUM_LANES-1:0]          rf_nop,
   output logic [NUM_LANES*IMM_W-1:0]    rf_imm
);

   localparam int HI_W   = IMM_W - FRAG_W;
   localparam int DATA_W = TOP_W - 1;
   localparam int SEXT_W = FRAG_W - BASE_IMM_W + 1;

   logic [NUM_LANES*IMM_W-1:0] imm_c;

   for (genvar i = 0; i < NUM_LANES; i++) begin : g_ln
      logic [FRAG_W-1:0] f_me;
      logic [IMM_W-1:0]  imm_l;
      logic [IMM_W-1:0]  imm_sx;

      assign f_me   = frag[i*FRAG_W +: FRAG_W];
      assign imm_sx = {{HI_W{f_me[FRAG_W-1]}}, f_me};
      assign imm_c[i*IMM_W +: IMM_W] = imm_l;

      if (i == 0) begin : g_first
         assign imm_l = lane_nop[i] ? '0 : imm_sx;

         AST_LANE0_UNEXTENDED: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |-> (kind[0] != FK_LONG && kind[0] != FK_HIGH)); // R2
      end else begin : g_rest
         logic [DATA_W-1:0] tdat;
         logic              tzero;
         logic [HI_W-1:0]   hi_top;

         assign tdat   = frag[(i-1)*FRAG_W +: DATA_W];
         assign tzero  = frag[(i-1)*FRAG_W + TOP_W - 1];
         assign hi_top = tzero ? {{(HI_W-DATA_W){1'b0}}, tdat}
                               : {{(HI_W-DATA_W){tdat[DATA_W-1]}}, tdat};

         always_comb begin
            if (lane_nop[i]) begin
               imm_l = '0;
            end else begin
               unique case (kind[i-1])
                  FK_HIGH: imm_l = {frag[(i-1)*FRAG_W +: HI_W], f_me};
                  FK_TOP:  imm_l = {hi_top, f_me};
                  default: imm_l = imm_sx;
               endcase
            end
         end

         AST_HIGH_AFTER_PREFIX: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid && kind[i] == FK_HIGH |-> (kind[i-1] == FK_TOP || kind[i-1] == FK_HIGH)); // R6
      end

      AST_SHORT_IS_SEXT: assert property (@(posedge clk) disable iff (!rst_n)
         in_valid && kind[i] == FK_SHORT |->
            (f_me[FRAG_W-1 -: SEXT_W] == {SEXT_W{f_me[FRAG_W-1]}})); // R3

      AST_NOP_IMM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
         rf_nop[i] |-> (rf_imm[i*IMM_W +: IMM_W] == '0)); // R11
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rf_valid <= 1'b0;
         rf_nop   <= '0;
         rf_imm   <= '0;
      end else begin
         rf_valid <= in_valid;
         if (in_valid) begin
            rf_nop <= lane_nop;
            rf_imm <= imm_c;
         end
      end
   end

   AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> rf_valid); // R7
   AST_IDLE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !rf_valid); // R7
   AST_HOLD_IMM: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(rf_imm)); // R13

endmodule

// File: rtl/jpx_lane_order.sv
module jpx_lane_order #(
   parameter int NUM_LANES   = 3,
   parameter int W           = 32,
   parameter bit RIGHT_ALIGN = 1'b1
) (
   input  logic [NUM_LANES*W-1:0] prog_bus,
   output logic [NUM_LANES*W-1:0] phys_bus
);

   for (genvar p = 0; p < NUM_LANES; p++) begin : g_slot
      if (RIGHT_ALIGN) begin : g_rev
         assign phys_bus[p*W +: W] = prog_bus[(NUM_LANES-1-p)*W +: W];
      end else begin : g_fwd
         assign phys_bus[p*W +: W] = prog_bus[p*W +: W];
      end
   end

endmodule

// File: rtl/jpx_imm_assembler.sv
module jpx_imm_assembler
   import jpx_pkg::*;
#(
   parameter int                NUM_LANES   = 3,
   parameter int                WORD_W      = 32,
   parameter int                TAG_W       = 6,
   parameter logic [TAG_W-1:0]  PFX_TAG     = '1,
   parameter int                BASE_IMM_W  = 12,
   parameter int                FRAG_W      = 33,
   parameter int                IMM_W       = 64,
   parameter bit                RIGHT_ALIGN = 1'b1,
   parameter logic [WORD_W-1:0] NOP_OP      = '0
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          in_valid,
   input  logic [NUM_LANES*WORD_W-1:0]   in_words,
   output logic [NUM_LANES*WORD_W-1:0]   dec_op,
   output logic [NUM_LANES-1:0]          dec_nop,
   output logic [NUM_LANES*FRAG_W-1:0]   dec_frag,
   output logic                          rf_valid,
   output logic [NUM_LANES-1:0]          rf_nop,
   output logic [NUM_LANES*IMM_W-1:0]    rf_imm
);

   localparam int PAY_W    = WORD_W - TAG_W;
   localparam int LOWEXT_W = FRAG_W - BASE_IMM_W;
   localparam int TOP_W    = PAY_W - LOWEXT_W;
   localparam int HI_W     = IMM_W - FRAG_W;

   // Elaboration-time parameter checks.
   if (NUM_LANES < 1) begin : g_chk_lanes
      $error("NUM_LANES must be at least 1");
   end
   if (LOWEXT_W < 1 || LOWEXT_W > PAY_W) begin : g_chk_lowext
      $error("prefix payload cannot fill the low fragment");
   end
   if (TOP_W < 2) begin : g_chk_top
      $error("payload leaves no room for mode and top data");
   end
   if (PAY_W + TOP_W != HI_W) begin : g_chk_hi
      $error("two-prefix encoding must exactly fill the high immediate");
   end
   if (HI_W >= FRAG_W) begin : g_chk_frag
      $error("high part must fit inside one fragment");
   end

   logic [NUM_LANES*WORD_W-1:0] op_prog;
   logic [NUM_LANES-1:0]        nop_prog;
   logic [NUM_LANES*FRAG_W-1:0] frag_prog;
   frag_kind_e [NUM_LANES-1:0]  kind_prog;
   logic [NUM_LANES-1:0]        rf_nop_prog;
   logic [NUM_LANES*IMM_W-1:0]  rf_imm_prog;

   for (genvar k = 0; k < NUM_LANES; k++) begin : g_lane
      logic [PAY_W-1:0] ext_pay;
      logic             ext_vld;

      if (k == 0) begin : g_head
         assign ext_pay = '0;
         assign ext_vld = 1'b0;
      end else begin : g_chain
         assign ext_pay = in_words[(k-1)*WORD_W + TAG_W +: PAY_W];
         assign ext_vld = nop_prog[k-1];
      end

      jpx_lane_dec #(
         .WORD_W     (WORD_W),
         .TAG_W      (TAG_W),
         .PFX_TAG    (PFX_TAG),
         .BASE_IMM_W (BASE_IMM_W),
         .FRAG_W     (FRAG_W),
         .NOP_OP     (NOP_OP)
      ) u_dec (
         .word    (in_words[k*WORD_W +: WORD_W]),
         .ext_pay (ext_pay),
         .ext_vld (ext_vld),
         .is_pfx  (nop_prog[k]),
         .op_out  (op_prog[k*WORD_W +: WORD_W]),
         .frag    (frag_prog[k*FRAG_W +: FRAG_W]),
         .kind    (kind_prog[k])
      );
   end

   jpx_imm_stitch #(
      .NUM_LANES  (NUM_LANES),
      .FRAG_W     (FRAG_W),
      .IMM_W      (IMM_W),
      .TOP_W      (TOP_W),
      .BASE_IMM_W (BASE_IMM_W)
   ) u_stitch (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (in_valid),
      .frag     (frag_prog),
      .kind     (kind_prog),
      .lane_nop (nop_prog),
      .rf_valid (rf_valid),
      .rf_nop   (rf_nop_prog),
      .rf_imm   (rf_imm_prog)
   );

   jpx_lane_order #(.NUM_LANES(NUM_LANES), .W(WORD_W), .RIGHT_ALIGN(RIGHT_ALIGN))
      u_ord_op   (.prog_bus(op_prog),     .phys_bus(dec_op));
   jpx_lane_order #(.NUM_LANES(NUM_LANES), .W(1), .RIGHT_ALIGN(RIGHT_ALIGN))
      u_ord_nop  (.prog_bus(nop_prog),    .phys_bus(dec_nop));
   jpx_lane_order #(.NUM_LANES(NUM_LANES), .W(FRAG_W), .RIGHT_ALIGN(RIGHT_ALIGN))
      u_ord_frag (.prog_bus(frag_prog),   .phys_bus(dec_frag));
   jpx_lane_order #(.NUM_LANES(NUM_LANES), .W(1), .RIGHT_ALIGN(RIGHT_ALIGN))
      u_ord_rnop (.prog_bus(rf_nop_prog), .phys_bus(rf_nop));
   jpx_lane_order #(.NUM_LANES(NUM_LANES), .W(IMM_W), .RIGHT_ALIGN(RIGHT_ALIGN))
      u_ord_rimm (.prog_bus(rf_imm_prog), .phys_bus(rf_imm));

   for (genvar p = 0; p < NUM_LANES; p++) begin : g_chk_slot
      AST_NOP_OP_ZEROED: assert property (@(posedge clk) disable iff (!rst_n)
         in_valid && dec_nop[p] |-> (dec_op[p*WORD_W +: WORD_W] == NOP_OP)); // R1
   end

endmodule

// File: tb/jpx_imm_assembler_bench.sv
module jpx_imm_assembler_bench;

   localparam int CLK_PERIOD = 10;
   localparam int N = 3;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           in_valid = 1'b0;
   logic [N*32-1:0] in_words = '0;
   logic [N*32-1:0] dec_op;
   logic [N-1:0]    dec_nop;
   logic [N*33-1:0] dec_frag;
   logic            rf_valid;
   logic [N-1:0]    rf_nop;
   logic [N*64-1:0] rf_imm;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   jpx_imm_assembler u_jpx_imm_assembler (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_words(in_words),
      .dec_op(dec_op), .dec_nop(dec_nop), .dec_frag(dec_frag),
      .rf_valid(rf_valid), .rf_nop(rf_nop), .rf_imm(rf_imm)
   );

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic bit pf(logic [31:0] x);
      return x[5:0] == 6'h3F;
   endfunction

   // Fragment per R3..R6
   function automatic logic [32:0] mfrag(logic [31:0] x, logic [31:0] p, bit hasp);
      if (!pf(x)) begin
         if (hasp && pf(p)) return {p[26:6], x[31:20]};
         return {{21{x[31]}}, x[31:20]};
      end
      if (hasp && pf(p)) return {2'b00, p[31:6], x[31:27]};
      return {28'd0, x[31:27]};
   endfunction

   function automatic logic [63:0] mimm(logic [31:0] w0, logic [31:0] w1, logic [31:0] w2, int k);
      logic [31:0] w [3];
      logic [32:0] fk, fp;
      logic [30:0] hi;
      w[0] = w0; w[1] = w1; w[2] = w2;
      if (pf(w[k])) return 64'd0;                                  // R11
      fk = mfrag(w[k], (k > 0) ? w[k-1] : 32'd0, k > 0);
      if (k >= 2 && pf(w[k-1]) && pf(w[k-2])) begin                // R10
         fp = mfrag(w[k-1], w[k-2], 1'b1);
         return {fp[30:0], fk};
      end
      if (k >= 1 && pf(w[k-1])) begin                              // R9
         hi = w[k-1][31] ? {27'd0, w[k-1][30:27]} : {{27{w[k-1][30]}}, w[k-1][30:27]};
         return {hi, fk};
      end
      return {{31{fk[32]}}, fk};                                   // R8
   endfunction

   task automatic run_bundle(input logic [31:0] w0, input logic [31:0] w1, input logic [31:0] w2);
      logic [31:0] w [3];
      w[0] = w0; w[1] = w1; w[2] = w2;
      in_words = {w2, w1, w0};
      in_valid = 1'b1;
      #1;
      for (int p = 0; p < N; p++) begin
         int k;
         logic [31:0] eop;
         logic [32:0] ef;
         k   = N - 1 - p;                                          // R12 slot mapping
         eop = pf(w[k]) ? 32'd0 : w[k];
         ef  = mfrag(w[k], (k > 0) ? w[k-1] : 32'd0, k > 0);
         chk(dec_op[p*32 +: 32] == eop, "R1/R12 op", 64'(dec_op[p*32 +: 32]), 64'(eop));
         chk(dec_nop[p] == pf(w[k]), "R1 nop", 64'(dec_nop[p]), 64'(pf(w[k])));
         chk(dec_frag[p*33 +: 33] == ef, "R2/R3/R4/R5/R6 frag", 64'(dec_frag[p*33 +: 33]), 64'(ef));
      end
      @(negedge clk);
      chk(rf_valid == 1'b1, "R7 valid", 64'(rf_valid), 64'd1);
      for (int p = 0; p < N; p++) begin
         int k;
         logic [63:0] ei;
         k  = N - 1 - p;
         ei = mimm(w0, w1, w2, k);
         chk(rf_imm[p*64 +: 64] == ei, "R8/R9/R10/R11 imm", rf_imm[p*64 +: 64], ei);
         chk(rf_nop[p] == pf(w[k]), "R11 rf_nop", 64'(rf_nop[p]), 64'(pf(w[k])));
      end
   endtask

   function automatic logic [31:0] rnd_word();
      logic [31:0] x;
      x = $urandom;
      if ($urandom_range(0, 9) < 4) x[5:0] = 6'h3F;
      else if (x[5:0] == 6'h3F) x[5:0] = 6'h01;
      return x;
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++; fails++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [63:0] held;
      void'($urandom(32'd1357));
      repeat (3) @(negedge clk);
      chk(rf_valid == 1'b0, "R13 reset valid", 64'(rf_valid), 64'd0);
      chk(rf_imm == '0, "R13 reset imm", rf_imm[63:0], 64'd0);
      chk(rf_nop == '0, "R13 reset nop", 64'(rf_nop), 64'd0);
      rst_n = 1'b1;

      // Directed corners
      run_bundle(32'h8001_2000, 32'h7FF0_0011, 32'h1230_0004);   // R3 R8 no prefix, negative and positive
      run_bundle(32'hFFFF_FFFF, 32'hABC0_0002, 32'h0010_0003);   // R2 R4 R9 one prefix, lane 0
      run_bundle(32'h0000_0005, 32'hD555_557F, 32'h9870_0008);   // R9 zero-extend mode, bit31=1
      run_bundle(32'h0000_0005, 32'h5555_557F, 32'h9870_0008);   // R9 sign-extend mode, bit31=0
      run_bundle(32'h1234_56FF, 32'hFEDC_BA7F, 32'h0F00_000A);   // R6 R10 two prefixes
      run_bundle(32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF);   // R5 R6 R11 all prefixes
      run_bundle(32'h4560_0001, 32'h0000_0002, 32'hCAFE_BABF);   // R5 R11 dangling prefix in lane 2
      run_bundle(32'h0000_0001, 32'hFFFF_FFFF, 32'hFFF0_0001);   // R9 top data all ones

      // Hold with in_valid low
      held = rf_imm[63:0];
      in_valid = 1'b0;
      in_words = {32'h1111_1111, 32'h2222_2222, 32'h3333_33FF};
      @(negedge clk);
      chk(rf_valid == 1'b0, "R7 idle valid", 64'(rf_valid), 64'd0);
      chk(rf_imm[63:0] == held, "R13 hold imm", rf_imm[63:0], held);
      @(negedge clk);
      chk(rf_imm[63:0] == held, "R13 hold imm 2", rf_imm[63:0], held);

      for (int i = 0; i < 400; i++) begin
         run_bundle(rnd_word(), rnd_word(), rnd_word());
      end

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule